// File: doc/BRIEF.md
# Dead-Block Bypass Predictor with Per-Line Reuse Counters

This block sits beside a small set-associative data cache and decides, for every miss fill, whether the incoming line should be placed in the cache or handed straight to the requester without insertion. It learns from lines that have already left the cache. Every resident line carries a saturating counter of the hits it received, the folded hashes of its block address and of the PC that brought it in, and a reuse threshold copied from the prediction table at insertion time. When a line is evicted, its final hit count is written into a two-dimensional table whose row is selected by the address hash and whose column is selected by the PC hash.

Each table entry holds a recorded count and a confidence bit. Confidence is set only when an eviction reports the same count that the entry already held, and it is cleared by any mismatch. A fill is bypassed only when the entry it selects is confident and its recorded count is zero. An inserted line whose entry was confident becomes armed: once its counter reaches the copied threshold, every further hit on it is reported as a hit on a dead line.

Each line follows a small state machine. LN_EMPTY moves to LN_LIVE when a fill is inserted into the line. LN_LIVE moves to LN_DEAD when an armed line's counter reaches its threshold on a hit. LN_LIVE and LN_DEAD both move back to LN_EMPTY on eviction. Any state moves to LN_LIVE when a new line is inserted into the slot. The cache data array and the choice of victim are outside this block. The cache names the slot of every fill, hit and eviction.

Top module: `dbp_bypass_predictor`

## Requirements
- R1: After reset every line is LN_EMPTY, every table entry holds count 15 with confidence clear, all outputs are low, and no fill is bypassed until training has occurred.
- R2: The address hash is the 3-bit XOR fold of fill_addr[11:6] (bit 6+i feeds hash bit i mod 3). The PC hash is the 3-bit XOR fold of fill_pc[7:2] (bit 2+i feeds hash bit i mod 3). The entry selected is row = address hash, column = PC hash.
- R3: One cycle after fill_valid, dec_valid is 1, and dec_bypass is 1 exactly when the selected entry is confident and its count is 0. With no fill, dec_valid and dec_bypass are 0.
- R4: A fill that is not bypassed loads slot fill_line with counter 0, the entry's count as threshold, and armed equal to the entry's confidence.
- R5: Each hit on a non-empty line adds one to its counter, which saturates at 15 and never wraps.
- R6: One cycle after hit_valid, hit_resp_valid is 1. hit_resp_dead is 1 when the line is armed and its counter after the hit is at least its threshold, or when the line was already dead. A hit on an empty line reports 0 and changes nothing.
- R7: Evicting a non-empty line writes its counter into the entry at its stored hashes. Confidence becomes 1 if the previous entry count equals the new one, and 0 otherwise. Evicting an empty line changes nothing.
- R8: A bypassed fill leaves the slot named by fill_line unchanged, including its counter, threshold and state.
- R9: When an eviction and a fill occur in the same cycle, the fill's lookup sees the table before the eviction's write. If both name the same slot, the eviction uses the old line contents and the fill then loads the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Miss fill request |
| fill_addr | input | 12 | Byte address of the fill |
| fill_pc | input | 8 | PC of the missing access |
| fill_line | input | 2 | Slot that receives the fill if inserted |
| hit_valid | input | 1 | Hit event |
| hit_line | input | 2 | Slot that was hit |
| evict_valid | input | 1 | Eviction event |
| evict_line | input | 2 | Slot being evicted |
| dec_valid | output | 1 | Decision valid, one cycle after a fill |
| dec_bypass | output | 1 | 1 = bypass, 0 = insert |
| hit_resp_valid | output | 1 | Hit response valid, one cycle after a hit |
| hit_resp_dead | output | 1 | The hit landed on a line now predicted dead |

## Verification
A wrong table entry is not visible when the eviction writes it. It appears at dec_bypass on the next fill that selects that entry, or as a threshold that is too early or too late in hit_resp_dead on the hits that follow. A wrong line counter, threshold or state shows up within the next hits to that slot, because the first dead report moves by at least one hit. A corrupted slot after a bypass, or a wrong read-before-write order in a shared cycle, changes the armed flag or the threshold of the reloaded line, which becomes visible within two hits. The sweep therefore trains every table entry twice with its own reuse count and then reads it back through a fill, using addresses whose upper fold bits vary.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_LIVE  = 2'd1,
        LN_DEAD  = 2'd2
    } line_state_e;

endpackage

// File: rtl/dbp_fold.sv
module dbp_fold #(
    parameter int IN_W  = 6,
    parameter int OUT_W = 3
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    // XOR fold: input bit i lands on output bit i mod OUT_W
    always_comb begin
        dout = '0;
        for (int i = 0; i < IN_W; i++) begin
            dout[i % OUT_W] = dout[i % OUT_W] ^ din[i];
        end
    end

endmodule

// File: rtl/dbp_pred_table.sv
module dbp_pred_table #(
    parameter int AH_W  = 3,
    parameter int PH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AH_W-1:0]  rd_ha,
    input  logic [PH_W-1:0]  rd_hp,
    output logic [CNT_W-1:0] rd_cnt,
    output logic             rd_conf,
    input  logic             wr_en,
    input  logic [AH_W-1:0]  wr_ha,
    input  logic [PH_W-1:0]  wr_hp,
    input  logic [CNT_W-1:0] wr_cnt
);

    localparam int IDX_W   = AH_W + PH_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [CNT_W-1:0]   cnt_q [ENTRIES];
    logic [ENTRIES-1:0] conf_q;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;

    assign rd_idx = {rd_ha, rd_hp};
    assign wr_idx = {wr_ha, wr_hp};

    // Read is combinational: a same-cycle write is not visible yet
    always_comb begin
        rd_cnt  = cnt_q[rd_idx];
        rd_conf = conf_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                cnt_q[e] <= '1;
            end
            conf_q <= '0;
        end else if (wr_en) begin
            conf_q[wr_idx] <= (cnt_q[wr_idx] == wr_cnt);
            cnt_q[wr_idx]  <= wr_cnt;
        end
    end

    AST_CONF_DROPS_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (cnt_q[wr_idx] != wr_cnt)) |=> !conf_q[$past(wr_idx)]); // R7

    AST_EVICT_COUNT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q[$past(wr_idx)] == $past(wr_cnt))); // R7

endmodule

// File: rtl/dbp_line_meta.sv
module dbp_line_meta
    import dbp_pkg::*;
#(
    parameter int AH_W  = 3,
    parameter int PH_W  = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AH_W-1:0]  load_ha,
    input  logic [PH_W-1:0]  load_hp,
    input  logic [CNT_W-1:0] load_thr,
    input  logic             load_arm,
    input  logic             clear,
    input  logic             hit,
    output line_state_e      state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [AH_W-1:0]  ha_o,
    output logic [PH_W-1:0]  hp_o,
    output logic             dead_hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    line_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, thr_q, cnt_inc;
    logic [AH_W-1:0]  ha_q;
    logic [PH_W-1:0]  hp_q;
    logic             arm_q;
    logic             hit_ok;
    logic             reach;

    // A hit counts only on a resident line not being replaced this cycle
    assign hit_ok  = hit && !load && !clear && (state_q != LN_EMPTY);
    assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign reach   = arm_q && (cnt_inc >= thr_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_EMPTY: begin
                if (load) state_d = LN_LIVE;
            end
            LN_LIVE: begin
                if (load)                 state_d = LN_LIVE;
                else if (clear)           state_d = LN_EMPTY;
                else if (hit_ok && reach) state_d = LN_DEAD;
            end
            LN_DEAD: begin
                if (load)       state_d = LN_LIVE;
                else if (clear) state_d = LN_EMPTY;
            end
            default: state_d = LN_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            thr_q <= '0;
            arm_q <= 1'b0;
            ha_q  <= '0;
            hp_q  <= '0;
        end else if (load) begin
            cnt_q <= '0;
            thr_q <= load_thr;
            arm_q <= load_arm;
            ha_q  <= load_ha;
            hp_q  <= load_hp;
        end else if (hit_ok) begin
            cnt_q <= cnt_inc;
        end
    end

    always_comb begin
        state_o    = state_q;
        cnt_o      = cnt_q;
        ha_o       = ha_q;
        hp_o       = hp_q;
        dead_hit_o = hit_ok && ((state_q == LN_DEAD) || reach);
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ok && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX)); // R5

    AST_LOAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((cnt_q == '0) && (state_q == LN_LIVE))); // R4

    AST_EVICT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (state_q == LN_EMPTY)); // R7

    AST_DEAD_IS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_DEAD) |-> arm_q); // R6

    AST_EMPTY_HIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load && (state_q == LN_EMPTY)) |=> (state_q == LN_EMPTY)); // R6

endmodule

// File: rtl/dbp_bypass_predictor.sv
module dbp_bypass_predictor
    import dbp_pkg::*;
#(
    parameter int LINES    = 4,
    parameter int ADDR_W   = 12,
    parameter int OFFSET_W = 6,
    parameter int PC_W     = 8,
    parameter int PC_LSB   = 2,
    parameter int AH_W     = 3,
    parameter int PH_W     = 3,
    parameter int CNT_W    = 4,
    localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [PC_W-1:0]   fill_pc,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              hit_valid,
    input  logic [LINE_W-1:0] hit_line,
    input  logic              evict_valid,
    input  logic [LINE_W-1:0] evict_line,
    output logic              dec_valid,
    output logic              dec_bypass,
    output logic              hit_resp_valid,
    output logic              hit_resp_dead
);

    localparam int A_IN_W = ADDR_W - OFFSET_W;
    localparam int P_IN_W = PC_W - PC_LSB;

    logic [AH_W-1:0]  f_ha;
    logic [PH_W-1:0]  f_hp;
    logic [CNT_W-1:0] tb_cnt;
    logic             tb_conf;
    logic             bypass_w;

    line_state_e      st_l  [LINES];
    logic [CNT_W-1:0] cnt_l [LINES];
    logic [AH_W-1:0]  ha_l  [LINES];
    logic [PH_W-1:0]  hp_l  [LINES];
    logic [LINES-1:0] dead_v;

    line_state_e      ev_st;
    logic [CNT_W-1:0] ev_cnt;
    logic [AH_W-1:0]  ev_ha;
    logic [PH_W-1:0]  ev_hp;
    logic             ev_wr;

    logic dec_valid_q, dec_bypass_q, hresp_valid_q, hresp_dead_q;

    dbp_fold #(.IN_W(A_IN_W), .OUT_W(AH_W)) u_addr_fold (
        .din  (fill_addr[ADDR_W-1:OFFSET_W]),
        .dout (f_ha)
    );

    dbp_fold #(.IN_W(P_IN_W), .OUT_W(PH_W)) u_pc_fold (
        .din  (fill_pc[PC_W-1:PC_LSB]),
        .dout (f_hp)
    );

    always_comb begin
        ev_st  = st_l[evict_line];
        ev_cnt = cnt_l[evict_line];
        ev_ha  = ha_l[evict_line];
        ev_hp  = hp_l[evict_line];
        ev_wr  = evict_valid && (ev_st != LN_EMPTY);
    end

    dbp_pred_table #(.AH_W(AH_W), .PH_W(PH_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ha   (f_ha),
        .rd_hp   (f_hp),
        .rd_cnt  (tb_cnt),
        .rd_conf (tb_conf),
        .wr_en   (ev_wr),
        .wr_ha   (ev_ha),
        .wr_hp   (ev_hp),
        .wr_cnt  (ev_cnt)
    );

    assign bypass_w = tb_conf && (tb_cnt == '0);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic ld, clr, ht;
        assign ld  = fill_valid  && !bypass_w && (fill_line == LINE_W'(g));
        assign clr = evict_valid && (evict_line == LINE_W'(g));
        assign ht  = hit_valid   && (hit_line == LINE_W'(g));

        dbp_line_meta #(.AH_W(AH_W), .PH_W(PH_W), .CNT_W(CNT_W)) u_meta (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (ld),
            .load_ha    (f_ha),
            .load_hp    (f_hp),
            .load_thr   (tb_cnt),
            .load_arm   (tb_conf),
            .clear      (clr),
            .hit        (ht),
            .state_o    (st_l[g]),
            .cnt_o      (cnt_l[g]),
            .ha_o       (ha_l[g]),
            .hp_o       (hp_l[g]),
            .dead_hit_o (dead_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_q   <= 1'b0;
            dec_bypass_q  <= 1'b0;
            hresp_valid_q <= 1'b0;
            hresp_dead_q  <= 1'b0;
        end else begin
            dec_valid_q   <= fill_valid;
            dec_bypass_q  <= fill_valid && bypass_w;
            hresp_valid_q <= hit_valid;
            hresp_dead_q  <= hit_valid && (|dead_v);
        end
    end

    always_comb begin
        dec_valid      = dec_valid_q;
        dec_bypass     = dec_bypass_q;
        hit_resp_valid = hresp_valid_q;
        hit_resp_dead  = hresp_dead_q;
    end

    AST_DEC_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> dec_valid); // R3

    AST_NO_DEC_WITHOUT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> (!dec_valid && !dec_bypass)); // R3

    AST_DEAD_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_resp_dead |-> hit_resp_valid); // R6

    AST_SINGLE_DEAD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dead_v)); // R6

endmodule

// File: tb/test_dbp_bypass_predictor.sv
`timescale 1ns/1ps
module test_dbp_bypass_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fill_valid;
    logic [11:0] fill_addr;
    logic [7:0]  fill_pc;
    logic [1:0]  fill_line;
    logic        hit_valid;
    logic [1:0]  hit_line;
    logic        evict_valid;
    logic [1:0]  evict_line;
    logic        dec_valid, dec_bypass, hit_resp_valid, hit_resp_dead;

    int n_checks = 0;
    int n_errors = 0;

    // Model state, built from the requirements
    int m_cnt  [64];
    bit m_conf [64];
    bit l_v    [4];
    bit l_arm  [4];
    bit l_dead [4];
    int l_cnt  [4];
    int l_thr  [4];
    int l_idx  [4];

    always #2 clk = ~clk;

    dbp_bypass_predictor i_dbp_bypass_predictor (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_pc(fill_pc), .fill_line(fill_line),
        .hit_valid(hit_valid), .hit_line(hit_line),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .dec_valid(dec_valid), .dec_bypass(dec_bypass),
        .hit_resp_valid(hit_resp_valid), .hit_resp_dead(hit_resp_dead)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk_addr(input int ha, input int k);
        logic [11:0] a;
        a[11:9] = 3'(k);
        a[8:6]  = 3'(ha) ^ 3'(k);
        a[5:0]  = 6'h15;
        return a;
    endfunction

    function automatic logic [7:0] mk_pc(input int hp, input int k);
        logic [7:0] p;
        p[7:5] = 3'(k + 1);
        p[4:2] = 3'(hp) ^ 3'(k + 1);
        p[1:0] = 2'b10;
        return p;
    endfunction

    // R2: row = addr[8:6]^addr[11:9], column = pc[4:2]^pc[7:5]
    function automatic int idx_of(input logic [11:0] a, input logic [7:0] p);
        return int'(a[8:6] ^ a[11:9]) * 8 + int'(p[4:2] ^ p[7:5]);
    endfunction

    function automatic bit pred_bypass(input int e);
        return m_conf[e] && (m_cnt[e] == 0);
    endfunction

    function automatic void model_insert(input int ln, input int e);
        l_v[ln]    = 1'b1;
        l_cnt[ln]  = 0;
        l_thr[ln]  = m_cnt[e];
        l_arm[ln]  = m_conf[e];
        l_dead[ln] = 1'b0;
        l_idx[ln]  = e;
    endfunction

    function automatic void model_evict(input int ln);
        if (l_v[ln]) begin
            m_conf[l_idx[ln]] = (m_cnt[l_idx[ln]] == l_cnt[ln]);
            m_cnt[l_idx[ln]]  = l_cnt[ln];
            l_v[ln] = 1'b0;
        end
    endfunction

    task automatic do_fill(input int ha, input int hp, input int k, input int ln, input string tag);
        logic [11:0] a;
        logic [7:0]  p;
        int          e;
        bit          exp_b;
        a = mk_addr(ha, k);
        p = mk_pc(hp, k);
        e = idx_of(a, p);
        exp_b = pred_bypass(e);
        fill_valid = 1'b1; fill_addr = a; fill_pc = p; fill_line = 2'(ln);
        @(negedge clk);
        fill_valid = 1'b0;
        check({tag, " dec_valid"}, int'(dec_valid), 1);
        check({tag, " dec_bypass"}, int'(dec_bypass), int'(exp_b));
        if (!exp_b) model_insert(ln, e);
    endtask

    task automatic do_hit(input int ln, input string tag);
        bit exp_d;
        hit_valid = 1'b1; hit_line = 2'(ln);
        @(negedge clk);
        hit_valid = 1'b0;
        exp_d = 1'b0;
        if (l_v[ln]) begin
            if (l_cnt[ln] < 15) l_cnt[ln]++;
            l_dead[ln] = l_dead[ln] || (l_arm[ln] && (l_cnt[ln] >= l_thr[ln]));
            exp_d = l_dead[ln];
        end
        check({tag, " hit_resp_valid"}, int'(hit_resp_valid), 1);
        check({tag, " hit_resp_dead"}, int'(hit_resp_dead), int'(exp_d));
    endtask

    task automatic do_evict(input int ln, input string tag);
        evict_valid = 1'b1; evict_line = 2'(ln);
        @(negedge clk);
        evict_valid = 1'b0;
        model_evict(ln);
        check({tag, " quiet outputs"}, int'(dec_valid) + int'(hit_resp_valid), 0);
    endtask

    // R9: eviction and fill in the same cycle
    task automatic do_evict_fill(input int evln, input int ha, input int hp, input int k,
                                 input int ln, input string tag);
        logic [11:0] a;
        logic [7:0]  p;
        int          e;
        bit          exp_b;
        a = mk_addr(ha, k);
        p = mk_pc(hp, k);
        e = idx_of(a, p);
        exp_b = pred_bypass(e);
        evict_valid = 1'b1; evict_line = 2'(evln);
        fill_valid = 1'b1; fill_addr = a; fill_pc = p; fill_line = 2'(ln);
        @(negedge clk);
        evict_valid = 1'b0; fill_valid = 1'b0;
        check({tag, " dec_valid"}, int'(dec_valid), 1);
        check({tag, " dec_bypass"}, int'(dec_bypass), int'(exp_b));
        begin
            int old_thr;
            bit old_arm;
            old_thr = m_cnt[e];
            old_arm = m_conf[e];
            model_evict(evln);
            if (!exp_b) begin
                model_insert(ln, e);
                l_thr[ln] = old_thr;
                l_arm[ln] = old_arm;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog (all requirements): act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int e = 0; e < 64; e++) begin
            m_cnt[e] = 15;
            m_conf[e] = 1'b0;
        end
        for (int l = 0; l < 4; l++) l_v[l] = 1'b0;
        rst_n = 1'b0;
        fill_valid = 1'b0; fill_addr = '0; fill_pc = '0; fill_line = '0;
        hit_valid = 1'b0; hit_line = '0; evict_valid = 1'b0; evict_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 dec_valid", int'(dec_valid), 0);
        check("R1 dec_bypass", int'(dec_bypass), 0);
        check("R1 hit_resp_valid", int'(hit_resp_valid), 0);
        check("R1 hit_resp_dead", int'(hit_resp_dead), 0);
        do_fill(5, 5, 0, 0, "R1");
        do_hit(0, "R1");
        do_evict(0, "R7");

        // R2 / R3: sweep every table entry, each trained twice with its own reuse count
        for (int a = 0; a < 8; a++) begin
            for (int p = 0; p < 8; p++) begin
                int c, ln, k;
                c  = (a + 2 * p) % 3;
                ln = (a + p) % 4;
                k  = (a * p) % 8;
                repeat (2) begin
                    do_fill(a, p, k, ln, "R2");
                    repeat (c) do_hit(ln, "R5");
                    do_evict(ln, "R7");
                end
                do_fill(a, p, (k + 3) % 8, ln, "R3");
                if (l_v[ln]) begin
                    repeat (c) do_hit(ln, "R4");
                    do_evict(ln, "R7");
                end
            end
        end

        // R5: saturation at 15, learned threshold of 15
        repeat (2) begin
            do_fill(1, 2, 4, 0, "R5");
            repeat (20) do_hit(0, "R5");
            do_evict(0, "R5");
        end
        do_fill(1, 2, 6, 0, "R5");
        repeat (16) do_hit(0, "R5");
        do_evict(0, "R5");

        // R4 / R6: confident threshold of 3
        repeat (2) begin
            do_fill(2, 4, 1, 2, "R4");
            repeat (3) do_hit(2, "R4");
            do_evict(2, "R7");
        end
        do_fill(2, 4, 7, 2, "R4");
        repeat (4) do_hit(2, "R6");
        do_evict(2, "R7");
        do_hit(2, "R6");  // hit on an emptied, formerly dead slot
        // R7: mismatch clears confidence
        do_fill(2, 4, 2, 2, "R7");
        repeat (6) do_hit(2, "R7");
        do_evict(2, "R7");
        // R7: eviction of an empty slot is ignored
        do_fill(2, 4, 3, 3, "R7");
        repeat (3) do_hit(3, "R7");
        do_evict(3, "R7");
        do_evict(3, "R7");
        do_fill(2, 4, 5, 3, "R7");
        repeat (4) do_hit(3, "R7");
        do_evict(3, "R7");

        // R8: bypassed fill leaves the slot untouched
        do_fill(0, 1, 5, 1, "R8");
        do_fill(0, 0, 2, 1, "R8");
        check("R8 bypass expected", int'(dec_bypass), 1);
        repeat (2) do_hit(1, "R8");
        do_evict(1, "R8");

        // R9: same-cycle eviction and fill on the same slot and entry
        do_fill(0, 1, 1, 2, "R9");
        do_evict_fill(2, 0, 1, 4, 2, "R9");
        repeat (2) do_hit(2, "R9");
        do_evict(2, "R9");
        do_fill(0, 1, 6, 3, "R9");
        repeat (2) do_hit(3, "R9");
        do_evict(3, "R9");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule